// File: doc/BRIEF.md
# FIFO Status and Interrupt Unit

This block sits between a serial engine and a simple register port. It holds two first-in first-out stores of equal depth: a transmit store that software fills through a data register and the engine drains, and a receive store that the engine fills and software drains through another data register. Both stores report their current fill level. Two threshold registers turn those levels into live events: transmit running low and receive holding more than a set count.

An interrupt unit combines the two live level events with four sticky error and line events: transmit overflow, receive underflow, receive overflow and select-inactive. It exposes raw status, a mask, masked status and a clear register with an all-clear bit. The single interrupt output is high whenever any masked status bit is set. A status register gives the full and empty flags of both stores, together with two busy flags passed through from the engine.

Register reads are combinational: `reg_rdata` reflects `reg_addr` in the same cycle. Writes, and the pop caused by reading receive data, take effect at the clock edge where `reg_wr` or `reg_rd` is high.

Top module: `fifo_irq_unit`

## Requirements
- R1: Word address 0 pushes `reg_wdata` into the transmit store, and `eng_tx_pop` removes its oldest entry, which is shown on `eng_tx_data`. `eng_rx_push` stores `eng_rx_data`, and a read of address 1 returns and removes the oldest receive entry. Addresses 2 and 3 read the transmit and receive levels (entry counts, 0 to DEPTH). Data leaves each store in arrival order.
- R2: A write to address 0 while the transmit store holds DEPTH entries is dropped, and it sets raw status bit 1 (transmit overflow). That bit stays set until it is cleared.
- R3: A read of address 1 while the receive store is empty returns zero, leaves the level at zero and sets sticky raw bit 2 (receive underflow).
- R4: An `eng_rx_push` while the receive store is full is dropped, and it sets sticky raw bit 3 (receive overflow).
- R5: Raw bit 4 is high exactly when the receive level is strictly greater than the receive threshold at address 5.
- R6: Raw bit 0 is high exactly when the transmit level is less than or equal to the transmit threshold at address 4.
- R7: Writes to addresses 4 and 5 take effect only while `enable` is low. While `enable` is high they are ignored, and a read of the address returns the old value.
- R8: Address 7 is the mask, address 9 reads raw status and address 8 reads masked status, which equals raw AND mask. `irq` is high exactly when masked status is nonzero.
- R9: A write to address 10 clears sticky events. Bit 0 clears raw bits 1, 2, 3 and 6. Bit 1 clears bit 2, bit 2 clears bit 3 and bit 3 clears bit 1. Clear bits have no effect on the live bits 0 and 4.
- R10: Status at address 6 has bit 0 = `eng_busy`, bit 1 = transmit full, bit 2 = transmit empty, bit 3 = receive empty, bit 4 = receive full and bit 5 = `eng_tgt_busy`.
- R11: A cycle with `eng_sel_inactive` high sets sticky raw bit 6.
- R12: After reset both levels are 0, both thresholds and the mask are 0, raw status is 0x01, status is 0x0C and `irq` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Global enable; while high, threshold writes are ignored |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe; pops the receive store at address 1 |
| reg_addr | input | 4 | Register word address |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data, combinational |
| eng_tx_pop | input | 1 | Engine takes the transmit head |
| eng_tx_data | output | DW | Transmit head entry (zero when empty) |
| eng_rx_push | input | 1 | Engine delivers a received word |
| eng_rx_data | input | DW | Received word |
| eng_busy | input | 1 | Engine busy flag, reported in status |
| eng_tgt_busy | input | 1 | Engine target-transmit busy flag, reported in status |
| eng_sel_inactive | input | 1 | Select-inactive event pulse |
| irq | output | 1 | Interrupt request |

## Verification
The assertions assume that `reg_wr` and `reg_rd` are never high in the same cycle, and that inputs change only between clock edges. The bench meets both by issuing one register operation per task call and driving it on the falling edge. The sticky-bit properties assume that a clear write is the only thing that removes an event. The stimulus therefore sends every clear through the clear register and never uses reset to drop sticky state in mid-run. The overflow and underflow checks push and pop only at a known full or empty level, so the dropped-access properties see the store at its limit.

// File: rtl/fiu_pkg.sv
package fiu_pkg;

    typedef enum logic [3:0] {
        A_TXDATA = 4'd0,
        A_RXDATA = 4'd1,
        A_TXLVL  = 4'd2,
        A_RXLVL  = 4'd3,
        A_TXTHR  = 4'd4,
        A_RXTHR  = 4'd5,
        A_STATUS = 4'd6,
        A_MASK   = 4'd7,
        A_MSTAT  = 4'd8,
        A_RAW    = 4'd9,
        A_CLEAR  = 4'd10
    } reg_addr_e;

    localparam int EVW     = 8;
    localparam int EV_TXE  = 0;
    localparam int EV_TXO  = 1;
    localparam int EV_RXU  = 2;
    localparam int EV_RXO  = 3;
    localparam int EV_RXT  = 4;
    localparam int EV_SEL  = 6;

    localparam int CLR_ALL = 0;
    localparam int CLR_RXU = 1;
    localparam int CLR_RXO = 2;
    localparam int CLR_TXO = 3;

    localparam logic [EVW-1:0] STICKY_SET =
        (EVW'(1) << EV_TXO) | (EVW'(1) << EV_RXU) |
        (EVW'(1) << EV_RXO) | (EVW'(1) << EV_SEL);

endpackage

// File: rtl/fiu_fifo.sv
module fiu_fifo #(
    parameter int DEPTH = 32,
    parameter int DW    = 16,
    localparam int PW   = $clog2(DEPTH),
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic [DW-1:0] push_data,
    input  logic          pop,
    output logic [DW-1:0] head_data,
    output logic [LW-1:0] level,
    output logic          full,
    output logic          empty
);

    typedef struct packed {
        logic [DEPTH-1:0][DW-1:0] mem;
        logic [PW-1:0]            wr;
        logic [PW-1:0]            rd;
        logic [LW-1:0]            cnt;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic     do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.cnt != LW'(DEPTH));
        do_pop  = pop && (st_q.cnt != '0);
        if (do_push) begin
            st_d.mem[st_q.wr] = push_data;
            st_d.wr           = st_q.wr + PW'(1);
        end
        if (do_pop) begin
            st_d.rd = st_q.rd + PW'(1);
        end
        st_d.cnt = st_q.cnt + LW'(do_push) - LW'(do_pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level     = st_q.cnt;
    assign full      = (st_q.cnt == LW'(DEPTH));
    assign empty     = (st_q.cnt == '0);
    assign head_data = empty ? '0 : st_q.mem[st_q.rd];

    AST_LEVEL_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
        level <= LW'(DEPTH)); // R1
    AST_FULL_DROP: assert property (@(posedge clk) disable iff (!rst_n)
        (push && full && !pop) |=> (level == LW'(DEPTH))); // R2
    AST_EMPTY_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (pop && empty) |-> (head_data == '0)); // R3

endmodule

// File: rtl/fiu_irq.sv
module fiu_irq
    import fiu_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           ev_txo,
    input  logic           ev_rxu,
    input  logic           ev_rxo,
    input  logic           ev_sel,
    input  logic           lv_txe,
    input  logic           lv_rxt,
    input  logic           mask_wr,
    input  logic [EVW-1:0] mask_wdata,
    input  logic           clr_wr,
    input  logic [3:0]     clr_wdata,
    output logic [EVW-1:0] raw,
    output logic [EVW-1:0] mask,
    output logic [EVW-1:0] masked,
    output logic           irq
);

    typedef struct packed {
        logic [EVW-1:0] sticky;
        logic [EVW-1:0] mask;
    } irq_st_t;

    irq_st_t        st_d, st_q;
    logic [EVW-1:0] clr_vec, set_vec;

    always_comb begin
        st_d    = st_q;
        clr_vec = '0;
        set_vec = '0;
        if (clr_wr) begin
            if (clr_wdata[CLR_ALL]) clr_vec = STICKY_SET;
            if (clr_wdata[CLR_RXU]) clr_vec[EV_RXU] = 1'b1;
            if (clr_wdata[CLR_RXO]) clr_vec[EV_RXO] = 1'b1;
            if (clr_wdata[CLR_TXO]) clr_vec[EV_TXO] = 1'b1;
        end
        set_vec[EV_TXO] = ev_txo;
        set_vec[EV_RXU] = ev_rxu;
        set_vec[EV_RXO] = ev_rxo;
        set_vec[EV_SEL] = ev_sel;
        st_d.sticky = (st_q.sticky & ~clr_vec) | set_vec;
        if (mask_wr) st_d.mask = mask_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        raw         = st_q.sticky;
        raw[EV_TXE] = lv_txe;
        raw[EV_RXT] = lv_rxt;
    end

    assign mask   = st_q.mask;
    assign masked = raw & st_q.mask;
    assign irq    = |masked;

    AST_TXO_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_txo |=> raw[EV_TXO]); // R2
    AST_RXO_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_rxo |=> raw[EV_RXO]); // R4
    AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (raw[EV_TXO] && !clr_wr) |=> raw[EV_TXO]); // R9
    AST_SEL_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        ev_sel |=> raw[EV_SEL]); // R11
    AST_NO_MASK_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq); // R8

endmodule

// File: rtl/fifo_irq_unit.sv
module fifo_irq_unit
    import fiu_pkg::*;
#(
    parameter int DEPTH = 32,
    parameter int DW    = 16,
    localparam int LW   = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          enable,
    input  logic          reg_wr,
    input  logic          reg_rd,
    input  logic [3:0]    reg_addr,
    input  logic [DW-1:0] reg_wdata,
    output logic [DW-1:0] reg_rdata,
    input  logic          eng_tx_pop,
    output logic [DW-1:0] eng_tx_data,
    input  logic          eng_rx_push,
    input  logic [DW-1:0] eng_rx_data,
    input  logic          eng_busy,
    input  logic          eng_tgt_busy,
    input  logic          eng_sel_inactive,
    output logic          irq
);

    typedef struct packed {
        logic [LW-1:0] tx_thr;
        logic [LW-1:0] rx_thr;
    } thr_st_t;

    thr_st_t        st_d, st_q;
    logic           tx_push, rx_pop;
    logic [LW-1:0]  tx_level, rx_level;
    logic           tx_full, tx_empty, rx_full, rx_empty;
    logic [DW-1:0]  rx_head;
    logic [EVW-1:0] raw, mask, masked;
    logic [5:0]     status;

    assign tx_push = reg_wr && (reg_addr == A_TXDATA);
    assign rx_pop  = reg_rd && (reg_addr == A_RXDATA);

    fiu_fifo #(.DEPTH(DEPTH), .DW(DW)) tx_fifo_i (
        .clk(clk), .rst_n(rst_n),
        .push(tx_push), .push_data(reg_wdata),
        .pop(eng_tx_pop), .head_data(eng_tx_data),
        .level(tx_level), .full(tx_full), .empty(tx_empty)
    );

    fiu_fifo #(.DEPTH(DEPTH), .DW(DW)) rx_fifo_i (
        .clk(clk), .rst_n(rst_n),
        .push(eng_rx_push), .push_data(eng_rx_data),
        .pop(rx_pop), .head_data(rx_head),
        .level(rx_level), .full(rx_full), .empty(rx_empty)
    );

    fiu_irq irq_i (
        .clk(clk), .rst_n(rst_n),
        .ev_txo(tx_push && tx_full),
        .ev_rxu(rx_pop && rx_empty),
        .ev_rxo(eng_rx_push && rx_full),
        .ev_sel(eng_sel_inactive),
        .lv_txe(tx_level <= st_q.tx_thr),
        .lv_rxt(rx_level > st_q.rx_thr),
        .mask_wr(reg_wr && (reg_addr == A_MASK)),
        .mask_wdata(reg_wdata[EVW-1:0]),
        .clr_wr(reg_wr && (reg_addr == A_CLEAR)),
        .clr_wdata(reg_wdata[3:0]),
        .raw(raw), .mask(mask), .masked(masked),
        .irq(irq)
    );

    always_comb begin
        st_d = st_q;
        if (reg_wr && !enable) begin
            if (reg_addr == A_TXTHR) st_d.tx_thr = reg_wdata[LW-1:0];
            if (reg_addr == A_RXTHR) st_d.rx_thr = reg_wdata[LW-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign status = {eng_tgt_busy, rx_full, rx_empty, tx_empty, tx_full, eng_busy};

    always_comb begin
        case (reg_addr)
            A_RXDATA: reg_rdata = rx_head;
            A_TXLVL:  reg_rdata = DW'(tx_level);
            A_RXLVL:  reg_rdata = DW'(rx_level);
            A_TXTHR:  reg_rdata = DW'(st_q.tx_thr);
            A_RXTHR:  reg_rdata = DW'(st_q.rx_thr);
            A_STATUS: reg_rdata = DW'(status);
            A_MASK:   reg_rdata = DW'(mask);
            A_MSTAT:  reg_rdata = DW'(masked);
            A_RAW:    reg_rdata = DW'(raw);
            default:  reg_rdata = '0;
        endcase
    end

    AST_THR_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        enable |=> ($stable(st_q.tx_thr) && $stable(st_q.rx_thr))); // R7
    AST_RXT_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_level == '0) |-> !raw[EV_RXT]); // R5
    AST_TXE_LIVE: assert property (@(posedge clk) disable iff (!rst_n)
        tx_empty |-> raw[EV_TXE]); // R6

endmodule

// File: tb/fifo_irq_unit_tb_top.sv
module fifo_irq_unit_tb_top;

    localparam int DEPTH = 32;
    localparam int DW    = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          enable = 1'b0;
    logic          reg_wr = 1'b0, reg_rd = 1'b0;
    logic [3:0]    reg_addr = '0;
    logic [DW-1:0] reg_wdata = '0;
    logic [DW-1:0] reg_rdata;
    logic          eng_tx_pop = 1'b0;
    logic [DW-1:0] eng_tx_data;
    logic          eng_rx_push = 1'b0;
    logic [DW-1:0] eng_rx_data = '0;
    logic          eng_busy = 1'b0, eng_tgt_busy = 1'b0, eng_sel_inactive = 1'b0;
    logic          irq;

    int checks = 0;
    int errors = 0;

    int txq[$];
    int rxq[$];
    int tx_thr = 0, rx_thr = 0;
    bit m_txo = 0, m_rxu = 0, m_rxo = 0, m_sel = 0;

    always #4 clk = ~clk;

    fifo_irq_unit #(.DEPTH(DEPTH), .DW(DW)) dut_i (
        .clk(clk), .rst_n(rst_n), .enable(enable),
        .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .eng_tx_pop(eng_tx_pop), .eng_tx_data(eng_tx_data),
        .eng_rx_push(eng_rx_push), .eng_rx_data(eng_rx_data),
        .eng_busy(eng_busy), .eng_tgt_busy(eng_tgt_busy),
        .eng_sel_inactive(eng_sel_inactive), .irq(irq)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int exp_raw();
        int r = 0;
        if (txq.size() <= tx_thr) r |= 1;
        if (m_txo) r |= 2;
        if (m_rxu) r |= 4;
        if (m_rxo) r |= 8;
        if (rxq.size() > rx_thr) r |= 16;
        if (m_sel) r |= 64;
        return r;
    endfunction

    task automatic op(input bit wr, input bit rd, input int a, input int wd, output int rdv);
        reg_wr = wr; reg_rd = rd; reg_addr = 4'(a); reg_wdata = DW'(wd);
        #1 rdv = int'(reg_rdata);
        @(negedge clk);
        reg_wr = 1'b0; reg_rd = 1'b0;
    endtask

    task automatic wreg(input int a, input int d);
        int dummy;
        op(1'b1, 1'b0, a, d, dummy);
    endtask

    task automatic rreg(input int a, output int v);
        op(1'b0, 1'b1, a, 0, v);
    endtask

    task automatic tx_write(input int d);
        wreg(0, d);
        if (txq.size() == DEPTH) m_txo = 1; else txq.push_back(d);
    endtask

    task automatic eng_pop(input string req);
        int v;
        eng_tx_pop = 1'b1;
        #1 v = int'(eng_tx_data);
        chk(req, v, txq.size() ? txq[0] : 0);
        @(negedge clk);
        eng_tx_pop = 1'b0;
        if (txq.size()) void'(txq.pop_front());
    endtask

    task automatic eng_push(input int d);
        eng_rx_push = 1'b1; eng_rx_data = DW'(d);
        @(negedge clk);
        eng_rx_push = 1'b0;
        if (rxq.size() == DEPTH) m_rxo = 1; else rxq.push_back(d);
    endtask

    task automatic rx_read(input string req);
        int v, e;
        e = rxq.size() ? rxq[0] : 0;
        if (rxq.size()) void'(rxq.pop_front()); else m_rxu = 1;
        rreg(1, v);
        chk(req, v, e);
    endtask

    task automatic chk_raw(input string req);
        int v;
        rreg(9, v);
        chk(req, v, exp_raw());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R12 reset state
        rreg(2, v); chk("R12 tx level", v, 0);
        rreg(3, v); chk("R12 rx level", v, 0);
        rreg(9, v); chk("R12 raw", v, 8'h01);
        rreg(6, v); chk("R12 status", v, 8'h0C);
        rreg(7, v); chk("R12 mask", v, 0);
        rreg(5, v); chk("R12 rx thr", v, 0);
        chk("R12 irq", int'(irq), 0);

        // R1 transmit fill sweep with levels
        for (int i = 0; i < DEPTH; i++) begin
            tx_write(i * 3 + 1);
            rreg(2, v); chk("R1 tx level", v, txq.size());
            chk_raw("R6 raw during fill");
        end
        rreg(6, v); chk("R10 status tx full", v, 8'h0A);
        // R2 overflow on full
        tx_write(16'hBEEF);
        rreg(2, v); chk("R2 tx level held", v, DEPTH);
        chk_raw("R2 overflow raw");
        // R1 engine drain order
        for (int i = 0; i < DEPTH; i++) eng_pop("R1 tx order");
        rreg(2, v); chk("R1 tx drained", v, 0);
        // R9 clear tx overflow with bit 3
        wreg(10, 8'h08); m_txo = 0;
        chk_raw("R9 clear txo");

        // R6 transmit threshold sweep
        for (int t = 0; t < 4; t++) begin
            wreg(4, t); tx_thr = t;
            for (int n = 0; n < 5; n++) begin
                chk_raw("R6 tx thr");
                tx_write(n + 100);
            end
            while (txq.size()) eng_pop("R1 tx order thr");
        end
        wreg(4, 0); tx_thr = 0;

        // R5 receive threshold sweep over every threshold
        for (int t = 0; t < DEPTH; t++) begin
            wreg(5, t); rx_thr = t;
            for (int n = 0; n < DEPTH; n++) begin
                eng_push(t * 64 + n);
                chk_raw("R5 rx thr");
            end
            rreg(3, v); chk("R1 rx level", v, DEPTH);
            while (rxq.size()) rx_read("R1 rx order");
        end
        wreg(5, 0); rx_thr = 0;

        // R4 receive overflow
        for (int n = 0; n < DEPTH; n++) eng_push(n + 7);
        rreg(6, v); chk("R10 status rx full", v, 8'h14);
        eng_push(16'h1234);
        rreg(3, v); chk("R4 rx level held", v, DEPTH);
        chk_raw("R4 rxo raw");
        while (rxq.size()) rx_read("R4 data kept");
        // R3 underflow
        rx_read("R3 empty read zero");
        rreg(3, v); chk("R3 level stays 0", v, 0);
        chk_raw("R3 rxu raw");
        wreg(10, 8'h02); m_rxu = 0;
        chk_raw("R9 clear rxu only");
        wreg(10, 8'h04); m_rxo = 0;
        chk_raw("R9 clear rxo");

        // R7 threshold lock while enabled
        wreg(5, 9); rx_thr = 9;
        enable = 1'b1;
        wreg(5, 3);
        wreg(4, 5);
        enable = 1'b0;
        rreg(5, v); chk("R7 rx thr locked", v, 9);
        rreg(4, v); chk("R7 tx thr locked", v, 0);
        wreg(5, 0); rx_thr = 0;

        // R11 select inactive, R9 all-clear
        eng_sel_inactive = 1'b1;
        @(negedge clk);
        eng_sel_inactive = 1'b0; m_sel = 1;
        chk_raw("R11 sel raw");
        for (int n = 0; n <= DEPTH; n++) tx_write(n);
        rx_read("R3 empty read again");
        for (int n = 0; n <= DEPTH; n++) eng_push(n);
        chk_raw("R9 all sticky set");
        wreg(10, 8'h01); m_txo = 0; m_rxu = 0; m_rxo = 0; m_sel = 0;
        chk_raw("R9 all clear");
        m_txo = 1; tx_write(5);
        m_sel = 1; eng_sel_inactive = 1'b1; @(negedge clk); eng_sel_inactive = 1'b0;

        // R8 full mask sweep
        for (int m = 0; m < 256; m++) begin
            wreg(7, m);
            rreg(8, v); chk("R8 masked", v, exp_raw() & m);
            chk("R8 irq", int'(irq), ((exp_raw() & m) != 0) ? 1 : 0);
        end

        // R10 busy passthrough
        eng_busy = 1'b1; eng_tgt_busy = 1'b1;
        rreg(6, v); chk("R10 busy flags", v, 8'h33);
        eng_busy = 1'b0; eng_tgt_busy = 1'b0;
        rreg(6, v); chk("R10 busy clear", v, 8'h12);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule